// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between a 32-bit register datapath and a memory bus that is one word wide. On the store side it takes a register value, an access size and the two low address bits. It drives the bus word with the stored value copied onto every lane it could occupy, and raises a write strobe for each byte lane the access touches. On the load side it takes the word read from the bus, the access size, a signed/unsigned select and the low address bits. It returns the addressed byte or halfword moved down to bit 0, with the upper bits either cleared or filled with the value's sign bit.

A run-time input chooses how byte addresses map onto lanes. When it is low, the order is little-endian. When it is high, the order is big-endian. Both paths have a single register stage, so every result appears on the clock edge after its request. The block does not compute addresses, hold memory or trap misaligned accesses.

Top module: `lane_aligner`

## Requirements
- R1: While reset is asserted and on the first cycle after it, both output valids are low and the strobes, bus data and load result are all zero.
- R2: Each request with its valid high gives its result, with the matching output valid high, exactly one clock later. An output valid is high for exactly those cycles.
- R3: A byte store (size code 2'b00) copies register bits 7:0 onto all four lanes and asserts one strobe. With little-endian order the strobe is bit k for address offset k. With big-endian order it is bit 3-k.
- R4: A halfword store (size code 2'b01) copies register bits 15:0 onto both bus halves and asserts two strobes. Address bit 0 is ignored. With little-endian order, address bit 1 = 0 gives strobes 4'b0011 and 1 gives 4'b1100. With big-endian order these two patterns are swapped.
- R5: A word store (size code 2'b10, and the spare code 2'b11) passes the register unchanged and asserts all four strobes, whatever the address offset and byte order.
- R6: An unsigned byte load (size 2'b00, signed select low) returns the addressed lane in bits 7:0 and zeros in bits 31:8. The lane is bus bits 8k+7:8k for offset k with little-endian order, and bits 8(3-k)+7:8(3-k) with big-endian order.
- R7: A signed byte load copies bit 7 of the selected byte into result bits 31:8.
- R8: An unsigned halfword load returns the addressed half in bits 15:0 and zeros above. With little-endian order, address bit 1 = 0 selects bus bits 15:0. With big-endian order it selects bits 31:16. The other half is selected when address bit 1 = 1.
- R9: A signed halfword load copies bit 15 of the selected half into result bits 31:16.
- R10: A word load returns the bus word unchanged, whatever the offset, the signed select or the byte order.
- R11: After 0x11223344 is stored as a word, a byte load from offset 0 returns 0x44 with little-endian order and 0x11 with big-endian order.
- R12: In a cycle after one with no store request, the strobes and bus data are zero. In a cycle after one with no load request, the load result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Byte order: 0 little-endian, 1 big-endian |
| st_valid | input | 1 | Store request present |
| st_size | input | 2 | Store size: 00 byte, 01 halfword, 10/11 word |
| st_addr_lo | input | 2 | Store byte offset within the word |
| st_data | input | 32 | Register value to store |
| st_out_valid | output | 1 | Store outputs valid |
| st_bus_data | output | 32 | Bus write data, with copies on the lanes |
| st_strobe | output | 4 | Per-lane write enables |
| ld_valid | input | 1 | Load request present |
| ld_size | input | 2 | Load size: 00 byte, 01 halfword, 10/11 word |
| ld_signed | input | 1 | 1 sign-extends, 0 zero-extends |
| ld_addr_lo | input | 2 | Load byte offset within the word |
| ld_bus_data | input | 32 | Word read from the bus |
| ld_out_valid | output | 1 | Load result valid |
| ld_result | output | 32 | Register value moved down to bit 0 and extended |

## Verification
Stores are applied for every size, offset and byte order with a register value whose four bytes all differ. A result taken from the wrong source byte, or a strobe on the wrong lane, therefore shows up. Loads read the word 0x11223344, where each lane is unique, to separate lane selection in the two byte orders. They also read 0x80FF7F01 and 0x7F018000, whose lanes mix set and clear top bits, so that sign extension can be told apart from zero fill for both a byte and a halfword. Idle cycles between requests show that outputs clear when there is no request. The word round trip checks the byte-order example.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_SPARE = 2'b11
    } acc_size_e;

    // Physical slot index for logical slot k out of n slots, given the byte order.
    function automatic int phys_slot(input logic big_end, input int k, input int n);
        return big_end ? (n - 1 - k) : k;
    endfunction

endpackage

// File: rtl/lane_map.sv
module lane_map
    import lane_align_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int ADDR_LO_W = 2
) (
    input  logic                 big_endian,
    input  logic [1:0]           size,
    input  logic [ADDR_LO_W-1:0] addr_lo,
    output logic [LANES-1:0]     lane_en
);
    localparam int HALVES = LANES / 2;

    acc_size_e size_e;
    int        byte_slot;
    int        half_slot;

    always_comb begin
        size_e    = acc_size_e'(size);
        byte_slot = phys_slot(big_endian, int'(addr_lo), LANES);
        half_slot = phys_slot(big_endian, int'(addr_lo >> 1), HALVES);
        for (int g = 0; g < LANES; g++) begin
            case (size_e)
                SZ_BYTE: lane_en[g] = (g == byte_slot);
                SZ_HALF: lane_en[g] = ((g / 2) == half_slot);
                default: lane_en[g] = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/store_packer.sv
module store_packer
    import lane_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] reg_data,
    output logic [DATA_W-1:0] bus_data
);
    localparam int LANES  = DATA_W / 8;
    localparam int HALVES = LANES / 2;

    logic [DATA_W-1:0] byte_rep;
    logic [DATA_W-1:0] half_rep;

    genvar gi;
    generate
        for (gi = 0; gi < LANES; gi++) begin : g_byte_rep
            assign byte_rep[8*gi +: 8] = reg_data[7:0];
        end
        for (gi = 0; gi < HALVES; gi++) begin : g_half_rep
            assign half_rep[16*gi +: 16] = reg_data[15:0];
        end
    endgenerate

    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: bus_data = byte_rep;
            SZ_HALF: bus_data = half_rep;
            default: bus_data = reg_data;
        endcase
    end

endmodule

// File: rtl/load_extract.sv
module load_extract
    import lane_align_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_LO_W = 2
) (
    input  logic                 big_endian,
    input  logic [1:0]           size,
    input  logic                 sign_ext,
    input  logic [ADDR_LO_W-1:0] addr_lo,
    input  logic [DATA_W-1:0]    bus_data,
    output logic [DATA_W-1:0]    result
);
    localparam int LANES  = DATA_W / 8;
    localparam int HALVES = LANES / 2;

    int          byte_slot;
    int          half_slot;
    logic [7:0]  byte_v;
    logic [15:0] half_v;

    always_comb begin
        byte_slot = phys_slot(big_endian, int'(addr_lo), LANES);
        half_slot = phys_slot(big_endian, int'(addr_lo >> 1), HALVES);
        byte_v    = bus_data[8*byte_slot +: 8];
        half_v    = bus_data[16*half_slot +: 16];
        case (acc_size_e'(size))
            SZ_BYTE: result = {{(DATA_W-8){sign_ext & byte_v[7]}}, byte_v};
            SZ_HALF: result = {{(DATA_W-16){sign_ext & half_v[15]}}, half_v};
            default: result = bus_data;
        endcase
    end

endmodule

// File: rtl/lane_aligner.sv
module lane_aligner
    import lane_align_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_LO_W = $clog2(DATA_W / 8)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  big_endian,
    input  logic                  st_valid,
    input  logic [1:0]            st_size,
    input  logic [ADDR_LO_W-1:0]  st_addr_lo,
    input  logic [DATA_W-1:0]     st_data,
    output logic                  st_out_valid,
    output logic [DATA_W-1:0]     st_bus_data,
    output logic [DATA_W/8-1:0]   st_strobe,
    input  logic                  ld_valid,
    input  logic [1:0]            ld_size,
    input  logic                  ld_signed,
    input  logic [ADDR_LO_W-1:0]  ld_addr_lo,
    input  logic [DATA_W-1:0]     ld_bus_data,
    output logic                  ld_out_valid,
    output logic [DATA_W-1:0]     ld_result
);
    localparam int LANES = DATA_W / 8;

    typedef struct packed {
        logic              st_vld;
        logic [DATA_W-1:0] st_data;
        logic [LANES-1:0]  st_strb;
        logic              ld_vld;
        logic [DATA_W-1:0] ld_data;
    } out_regs_t;

    out_regs_t         regs_d, regs_q;
    logic [LANES-1:0]  st_lane_en;
    logic [DATA_W-1:0] st_packed;
    logic [DATA_W-1:0] ld_extracted;

    lane_map #(.LANES(LANES), .ADDR_LO_W(ADDR_LO_W)) u_st_map (
        .big_endian (big_endian),
        .size       (st_size),
        .addr_lo    (st_addr_lo),
        .lane_en    (st_lane_en)
    );

    store_packer #(.DATA_W(DATA_W)) u_packer (
        .size     (st_size),
        .reg_data (st_data),
        .bus_data (st_packed)
    );

    load_extract #(.DATA_W(DATA_W), .ADDR_LO_W(ADDR_LO_W)) u_extract (
        .big_endian (big_endian),
        .size       (ld_size),
        .sign_ext   (ld_signed),
        .addr_lo    (ld_addr_lo),
        .bus_data   (ld_bus_data),
        .result     (ld_extracted)
    );

    always_comb begin
        regs_d         = '0;
        regs_d.st_vld  = st_valid;
        regs_d.ld_vld  = ld_valid;
        if (st_valid) begin
            regs_d.st_data = st_packed;
            regs_d.st_strb = st_lane_en;
        end
        if (ld_valid) begin
            regs_d.ld_data = ld_extracted;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign st_out_valid = regs_q.st_vld;
    assign st_bus_data  = regs_q.st_data;
    assign st_strobe    = regs_q.st_strb;
    assign ld_out_valid = regs_q.ld_vld;
    assign ld_result    = regs_q.ld_data;

endmodule

// File: rtl/lane_aligner_chk.sv
module lane_aligner_chk #(
    parameter int DATA_W    = 32,
    parameter int ADDR_LO_W = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 big_endian,
    input logic                 st_valid,
    input logic [1:0]           st_size,
    input logic [ADDR_LO_W-1:0] st_addr_lo,
    input logic [DATA_W-1:0]    st_data,
    input logic                 st_out_valid,
    input logic [DATA_W-1:0]    st_bus_data,
    input logic [DATA_W/8-1:0]  st_strobe,
    input logic                 ld_valid,
    input logic [1:0]           ld_size,
    input logic                 ld_signed,
    input logic [ADDR_LO_W-1:0] ld_addr_lo,
    input logic [DATA_W-1:0]    ld_bus_data,
    input logic                 ld_out_valid,
    input logic [DATA_W-1:0]    ld_result
);
    localparam int LANES = DATA_W / 8;

    p_st_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> st_out_valid);

    p_ld_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_out_valid);

    p_byte_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_size == 2'b00) |=> $countones(st_strobe) == 1);

    p_byte_le_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_size == 2'b00 && !big_endian) |=>
        (st_strobe == (LANES'(1) << $past(st_addr_lo))));

    p_byte_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_size == 2'b00) |=>
        (st_bus_data[7:0] == $past(st_data[7:0]) &&
         st_bus_data[DATA_W-1 -: 8] == $past(st_data[7:0])));

    p_half_two_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_size == 2'b01) |=> $countones(st_strobe) == 2);

    p_word_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_size[1]) |=> &st_strobe);

    p_ubyte_zero_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_size == 2'b00 && !ld_signed) |=> ld_result[DATA_W-1:8] == '0);

    p_ubyte_le_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_size == 2'b00 && !big_endian) |=>
        ld_result[7:0] == 8'($past(ld_bus_data) >> (8 * $past(ld_addr_lo))));

    p_sbyte_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_size == 2'b00 && ld_signed) |=>
        (ld_result[DATA_W-1:8] == {(DATA_W-8){ld_result[7]}}));

    p_uhalf_zero_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_size == 2'b01 && !ld_signed) |=> ld_result[DATA_W-1:16] == '0);

    p_shalf_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_size == 2'b01 && ld_signed) |=>
        (ld_result[DATA_W-1:16] == {(DATA_W-16){ld_result[15]}}));

    p_word_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_size[1]) |=> ld_result == $past(ld_bus_data));

    p_idle_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> (!st_out_valid && st_strobe == '0 && st_bus_data == '0));

    p_idle_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> (!ld_out_valid && ld_result == '0));

endmodule

bind lane_aligner lane_aligner_chk #(.DATA_W(DATA_W), .ADDR_LO_W(ADDR_LO_W)) chk_i (.*);

// File: tb/lane_aligner_tb_top.sv
`timescale 1ns/1ps
module lane_aligner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        big_endian;
    logic        st_valid;
    logic [1:0]  st_size;
    logic [1:0]  st_addr_lo;
    logic [31:0] st_data;
    logic        st_out_valid;
    logic [31:0] st_bus_data;
    logic [3:0]  st_strobe;
    logic        ld_valid;
    logic [1:0]  ld_size;
    logic        ld_signed;
    logic [1:0]  ld_addr_lo;
    logic [31:0] ld_bus_data;
    logic        ld_out_valid;
    logic [31:0] ld_result;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lane_aligner dut_i (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .st_valid(st_valid), .st_size(st_size), .st_addr_lo(st_addr_lo),
        .st_data(st_data), .st_out_valid(st_out_valid), .st_bus_data(st_bus_data),
        .st_strobe(st_strobe), .ld_valid(ld_valid), .ld_size(ld_size),
        .ld_signed(ld_signed), .ld_addr_lo(ld_addr_lo), .ld_bus_data(ld_bus_data),
        .ld_out_valid(ld_out_valid), .ld_result(ld_result)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_strb(input logic be, input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'b00: return be ? (4'b1000 >> a) : (4'b0001 << a);
            2'b01: return (a[1] ^ be) ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_sdata(input logic [1:0] sz, input logic [31:0] r);
        case (sz)
            2'b00: return {4{r[7:0]}};
            2'b01: return {2{r[15:0]}};
            default: return r;
        endcase
    endfunction

    // Memory view: byte at offset k of the word, per the chosen order.
    function automatic logic [7:0] mem_byte(input logic be, input logic [31:0] w, input int k);
        int bit_lo;
        bit_lo = be ? 8 * (3 - k) : 8 * k;
        return w[bit_lo +: 8];
    endfunction

    function automatic logic [31:0] exp_load(input logic be, input logic [1:0] sz, input logic sg,
                                             input logic [1:0] a, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        int base;
        b = mem_byte(be, w, int'(a));
        base = int'(a) & 2;
        // value in register order: little-endian low byte first, big-endian high byte first
        h = be ? {mem_byte(be, w, base), mem_byte(be, w, base + 1)}
               : {mem_byte(be, w, base + 1), mem_byte(be, w, base)};
        case (sz)
            2'b00: return sg ? {{24{b[7]}}, b} : {24'h0, b};
            2'b01: return sg ? {{16{h[15]}}, h} : {16'h0, h};
            default: return w;
        endcase
    endfunction

    function automatic string ld_tag(input logic [1:0] sz, input logic sg);
        case (sz)
            2'b00: return sg ? "R7 signed byte load" : "R6 unsigned byte load";
            2'b01: return sg ? "R9 signed half load" : "R8 unsigned half load";
            default: return "R10 word load";
        endcase
    endfunction

    function automatic string st_tag(input logic [1:0] sz);
        case (sz)
            2'b00: return "R3 byte store";
            2'b01: return "R4 half store";
            default: return "R5 word store";
        endcase
    endfunction

    task automatic idle_inputs();
        st_valid = 1'b0; st_size = 2'b00; st_addr_lo = 2'b00; st_data = '0;
        ld_valid = 1'b0; ld_size = 2'b00; ld_signed = 1'b0; ld_addr_lo = 2'b00; ld_bus_data = '0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0; big_endian = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        check("R1 st valid", {31'h0, st_out_valid}, 32'h0);
        check("R1 strobe", {28'h0, st_strobe}, 32'h0);
        check("R1 bus data", st_bus_data, 32'h0);
        check("R1 ld valid", {31'h0, ld_out_valid}, 32'h0);
        check("R1 ld result", ld_result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 st valid after release", {31'h0, st_out_valid}, 32'h0);
        check("R1 ld result after release", ld_result, 32'h0);
    endtask

    task automatic do_store(input logic be, input logic [1:0] sz, input logic [1:0] a, input logic [31:0] r);
        big_endian = be; st_valid = 1'b1; st_size = sz; st_addr_lo = a; st_data = r;
        @(negedge clk);
        check({st_tag(sz), " R2 valid"}, {31'h0, st_out_valid}, 32'h1);
        check({st_tag(sz), " strobe"}, {28'h0, st_strobe}, {28'h0, exp_strb(be, sz, a)});
        check({st_tag(sz), " data"}, st_bus_data, exp_sdata(sz, r));
        st_valid = 1'b0; st_data = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R12 idle strobe", {28'h0, st_strobe}, 32'h0);
        check("R12 idle data", st_bus_data, 32'h0);
        check("R2 st valid drops", {31'h0, st_out_valid}, 32'h0);
    endtask

    task automatic do_load(input logic be, input logic [1:0] sz, input logic sg,
                           input logic [1:0] a, input logic [31:0] w);
        big_endian = be; ld_valid = 1'b1; ld_size = sz; ld_signed = sg; ld_addr_lo = a; ld_bus_data = w;
        @(negedge clk);
        check({ld_tag(sz, sg), " R2 valid"}, {31'h0, ld_out_valid}, 32'h1);
        check(ld_tag(sz, sg), ld_result, exp_load(be, sz, sg, a, w));
        ld_valid = 1'b0; ld_bus_data = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R12 idle load result", ld_result, 32'h0);
    endtask

    task automatic test_stores();
        for (int be = 0; be < 2; be++)
            for (int sz = 0; sz < 4; sz++)
                for (int a = 0; a < 4; a++)
                    do_store(1'(be), 2'(sz), 2'(a), 32'hA5C3_7E19 ^ (32'(a) << 8));
    endtask

    task automatic test_loads();
        logic [31:0] pats [3];
        pats[0] = 32'h1122_3344; pats[1] = 32'h80FF_7F01; pats[2] = 32'h7F01_8000;
        for (int p = 0; p < 3; p++)
            for (int be = 0; be < 2; be++)
                for (int sz = 0; sz < 4; sz++)
                    for (int sg = 0; sg < 2; sg++)
                        for (int a = 0; a < 4; a++)
                            do_load(1'(be), 2'(sz), 1'(sg), 2'(a), pats[p]);
    endtask

    task automatic test_round_trip(input logic be, input logic [31:0] exp_byte);
        logic [31:0] word;
        big_endian = be; st_valid = 1'b1; st_size = 2'b10; st_addr_lo = 2'b00; st_data = 32'h1122_3344;
        @(negedge clk);
        word = st_bus_data;
        st_valid = 1'b0;
        check("R11 stored word", word, 32'h1122_3344);
        ld_valid = 1'b1; ld_size = 2'b00; ld_signed = 1'b0; ld_addr_lo = 2'b00; ld_bus_data = word;
        @(negedge clk);
        check("R11 byte from offset 0", ld_result, exp_byte);
        ld_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_back_to_back();
        big_endian = 1'b0;
        ld_valid = 1'b1; ld_size = 2'b00; ld_signed = 1'b1; ld_addr_lo = 2'b01; ld_bus_data = 32'h0000_8000;
        @(negedge clk);
        check("R7 first of pair", ld_result, 32'hFFFF_FF80);
        ld_addr_lo = 2'b10; ld_size = 2'b01; ld_signed = 1'b0; ld_bus_data = 32'hBEEF_0000;
        @(negedge clk);
        check("R2 second of pair valid", {31'h0, ld_out_valid}, 32'h1);
        check("R8 second of pair", ld_result, 32'h0000_BEEF);
        ld_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        test_reset();
        test_stores();
        test_loads();
        test_round_trip(1'b0, 32'h44);
        test_round_trip(1'b1, 32'h11);
        test_back_to_back();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule